// File: doc/BRIEF.md
# Banked Memory-Map Address Translator

This block sits between a CPU (and a DMA engine) and the physical memories of a small controller. It translates two 16-bit address streams at the same time. The first is the unified data space, used by both CPU and DMA. The second is the code space. For each access it produces a one-hot target select (flash, SRAM, radio register file, special-function register file, or nothing) and a physical offset into that target.

The translation is purely combinational and is evaluated within the same cycle. A third, narrow path maps the 8-bit direct-data address onto the top 256 bytes of SRAM.

A two-bit flash bank number and a unified-code-mode flag live in the block. The bank number can be reached through two register locations that mirror each other:
- a dedicated bank register port;
- the low field of a memory-control register port, which also carries the mode flag.

In the default (non-unified) code mode, the upper half of the code space is a 32 KB window onto one of four flash banks. In unified mode, the code space takes on the data-space layout. SRAM then becomes executable and the register files are overlaid. The parameter `FLASH_BANKS` selects between the four-bank (128 KB) flash option and the single-bank (32 KB) option.

Top module: `memmap_xlat`

## Requirements
- R1: After reset the bank number is 0 and the unified flag is 0. `bankRdData` reads 0 and `ctrlRdData` reads 0. Code address 0xF000 then maps to flash offset 0x07000.
- R2: Data-space decode, with the select encoded as bit0 flash, bit1 SRAM, bit2 radio, bit3 SFR, bit4 none:
  - 0xE000-0xFFFF selects SRAM at offset addr[12:0].
  - 0xDF80-0xDFFF selects SFR at offset addr[6:0].
  - 0xDF00-0xDF7F selects radio at offset addr[6:0].
  - 0x0000-0xDEFF selects flash at offset equal to the address, independent of the bank number.
- R3: In non-unified code mode with four banks:
  - code 0x0000-0x7FFF selects flash at offset equal to the address;
  - code 0x8000-0xFFFF selects flash at offset {bank, addr[14:0]}.
- R4: In unified code mode:
  - code 0x8000-0xDEFF selects flash at offset {bank, addr[14:0]};
  - code 0xDF00-0xFFFF never selects flash and decodes exactly as the data space does;
  - code below 0x8000 selects flash at offset equal to the address.
- R5: Bit 2 of a control-port write sets the unified flag. It is read back on `ctrlRdData[2]`.
- R6: A bank written through either port (`bankWrData`, or `ctrlWrData[1:0]`) is read back identically on `bankRdData` and `ctrlRdData[1:0]`.
- R7: When both ports write in the same cycle, the bank comes from `bankWrData`. The unified flag still comes from `ctrlWrData[2]`.
- R8: `directOff` equals 0x1F00 plus `directAddr`. This is the same SRAM offset that data address {0xFF, directAddr} produces.
- R9: A register write alters translation only after the rising edge that stores it, not in the cycle it is presented.
- R10: Exactly one select bit is set on `dSel` and on `cSel` for every address.
- R11: With `FLASH_BANKS` = 1, the following select none with offset 0:
  - data 0x8000-0xDEFF;
  - non-unified code 0x8000-0xFFFF;
  - unified code 0x8000-0xDEFF.
  
  Data and code 0x0000-0x7FFF still select flash.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| dAddr | input | 16 | Data-space address |
| dSel | output | 5 | Data-space one-hot target select |
| dOff | output | 17 | Data-space physical offset |
| cAddr | input | 16 | Code-space address |
| cSel | output | 5 | Code-space one-hot target select |
| cOff | output | 17 | Code-space physical offset |
| directAddr | input | 8 | Direct-data address |
| directOff | output | 13 | SRAM offset for the direct-data address |
| bankWrEn | input | 1 | Write strobe of the primary bank register |
| bankWrData | input | 2 | Bank value for the primary port |
| bankRdData | output | 2 | Bank value read through the primary port |
| ctrlWrEn | input | 1 | Write strobe of the memory-control register |
| ctrlWrData | input | 3 | {unified flag, bank} for the control port |
| ctrlRdData | output | 3 | {unified flag, bank} read through the control port |

## Verification
Address translation results are due in the same cycle as the address. The bench therefore drives addresses at the falling edge and samples 1 ns later, before the next rising edge.

Register writes are due one rising edge after the strobe. The bench applies each write at a falling edge and checks the mirrored reads and the changed mapping only after the following rising edge.

The R9 check samples twice: once in the write cycle, where the old bank must still apply, and once after the edge, where the new bank must apply.

// File: rtl/memmap_pkg.sv
package memmap_pkg;

  localparam int AddrW    = 16;
  localparam int BankW    = 2;
  localparam int FlashOffW = 17;
  localparam int SramOffW = 13;
  localparam int RegOffW  = 7;

  typedef enum logic [4:0] {
    TGT_FLASH = 5'b00001,
    TGT_SRAM  = 5'b00010,
    TGT_RADIO = 5'b00100,
    TGT_SFR   = 5'b01000,
    TGT_NONE  = 5'b10000
  } target_e;

  // Settings passed from the control module to the datapath
  typedef struct packed {
    logic [BankW-1:0] bankSel;
    logic             unifiedMode;
  } mapCfg_t;

endpackage

// File: rtl/memmap_ctrl.sv
module memmap_ctrl
  import memmap_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             bankWrEn,
  input  logic [BankW-1:0] bankWrData,
  input  logic             ctrlWrEn,
  input  logic [BankW:0]   ctrlWrData,
  output mapCfg_t          cfg
);

  logic [BankW-1:0] bankQ;
  logic             unifiedQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bankQ    <= '0;
      unifiedQ <= 1'b0;
    end else begin
      // primary port has priority on the shared bank field
      if (bankWrEn)
        bankQ <= bankWrData;
      else if (ctrlWrEn)
        bankQ <= ctrlWrData[BankW-1:0];
      if (ctrlWrEn)
        unifiedQ <= ctrlWrData[BankW];
    end
  end

  assign cfg.bankSel     = bankQ;
  assign cfg.unifiedMode = unifiedQ;

  // R7
  bank_prio_chk: assert property (@(posedge clk) disable iff (!rstN)
    (bankWrEn && ctrlWrEn) |=> (cfg.bankSel == $past(bankWrData)));

  // R6
  ctrl_mirror_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWrEn && !bankWrEn) |=> (cfg.bankSel == $past(ctrlWrData[BankW-1:0])));

  // R5
  mode_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWrEn |=> (cfg.unifiedMode == $past(ctrlWrData[BankW])));

  // R9
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!bankWrEn && !ctrlWrEn) |=> $stable(cfg));

endmodule

// File: rtl/memmap_dp.sv
module memmap_dp
  import memmap_pkg::*;
#(
  parameter int FLASH_BANKS = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  mapCfg_t              cfg,
  input  logic [AddrW-1:0]     dAddr,
  input  logic [AddrW-1:0]     cAddr,
  input  logic [7:0]           directAddr,
  output logic [4:0]           dSel,
  output logic [FlashOffW-1:0] dOff,
  output logic [4:0]           cSel,
  output logic [FlashOffW-1:0] cOff,
  output logic [SramOffW-1:0]  directOff
);

  localparam bit            BigFlash  = (FLASH_BANKS > 1);
  localparam logic [15:0]   SramBase  = 16'hE000;
  localparam logic [15:0]   SfrBase   = 16'hDF80;
  localparam logic [15:0]   RadioBase = 16'hDF00;
  localparam logic [15:0]   WinBase   = 16'h8000;
  localparam int            NumPorts  = 2;

  logic [AddrW-1:0]     addrV [NumPorts];
  target_e              selV  [NumPorts];
  logic [FlashOffW-1:0] offV  [NumPorts];

  assign addrV[0] = dAddr;
  assign addrV[1] = cAddr;

  for (genvar gi = 0; gi < NumPorts; gi++) begin : g_port
    localparam bit IsCode = (gi == 1);
    logic [AddrW-1:0] a;
    logic             banked;
    assign a = addrV[gi];
    // only the code port ever uses the bank number
    assign banked = IsCode;

    always_comb begin
      selV[gi] = TGT_NONE;
      offV[gi] = '0;
      if (banked && !cfg.unifiedMode) begin
        if (a < WinBase) begin
          selV[gi] = TGT_FLASH;
          offV[gi] = {1'b0, a};
        end else if (BigFlash) begin
          selV[gi] = TGT_FLASH;
          offV[gi] = {cfg.bankSel, a[14:0]};
        end
      end else begin
        if (a >= SramBase) begin
          selV[gi] = TGT_SRAM;
          offV[gi] = {4'b0, a[SramOffW-1:0]};
        end else if (a >= SfrBase) begin
          selV[gi] = TGT_SFR;
          offV[gi] = {10'b0, a[RegOffW-1:0]};
        end else if (a >= RadioBase) begin
          selV[gi] = TGT_RADIO;
          offV[gi] = {10'b0, a[RegOffW-1:0]};
        end else if (a < WinBase) begin
          selV[gi] = TGT_FLASH;
          offV[gi] = {1'b0, a};
        end else if (BigFlash) begin
          selV[gi] = TGT_FLASH;
          offV[gi] = banked ? {cfg.bankSel, a[14:0]} : {1'b0, a};
        end
      end
    end
  end

  assign dSel = selV[0];
  assign dOff = offV[0];
  assign cSel = selV[1];
  assign cOff = offV[1];

  // direct-data space lives in the last 256 bytes of SRAM
  assign directOff = {5'h1F, directAddr};

  // R10
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($countones(dSel) == 1) && ($countones(cSel) == 1));

  // R2
  data_sram_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dAddr[15:13] == 3'b111) |-> (dSel == TGT_SRAM && dOff[12:0] == dAddr[12:0]));

  // R3
  code_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!cAddr[15]) |-> (cSel == TGT_FLASH && cOff == {1'b0, cAddr}));

  // R4
  unified_noflash_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.unifiedMode && cAddr > 16'hDEFF) |-> (cSel != TGT_FLASH && cSel == dSel)
      || (cAddr != dAddr));

  // R8
  direct_alias_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dAddr == {8'hFF, directAddr}) |-> (dOff[SramOffW-1:0] == directOff));

endmodule

// File: rtl/memmap_xlat.sv
module memmap_xlat
  import memmap_pkg::*;
#(
  parameter int FLASH_BANKS = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [AddrW-1:0]     dAddr,
  output logic [4:0]           dSel,
  output logic [FlashOffW-1:0] dOff,
  input  logic [AddrW-1:0]     cAddr,
  output logic [4:0]           cSel,
  output logic [FlashOffW-1:0] cOff,
  input  logic [7:0]           directAddr,
  output logic [SramOffW-1:0]  directOff,
  input  logic                 bankWrEn,
  input  logic [BankW-1:0]     bankWrData,
  output logic [BankW-1:0]     bankRdData,
  input  logic                 ctrlWrEn,
  input  logic [BankW:0]       ctrlWrData,
  output logic [BankW:0]       ctrlRdData
);

  mapCfg_t cfg;

  memmap_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .bankWrEn   (bankWrEn),
    .bankWrData (bankWrData),
    .ctrlWrEn   (ctrlWrEn),
    .ctrlWrData (ctrlWrData),
    .cfg        (cfg)
  );

  memmap_dp #(.FLASH_BANKS(FLASH_BANKS)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .cfg        (cfg),
    .dAddr      (dAddr),
    .cAddr      (cAddr),
    .directAddr (directAddr),
    .dSel       (dSel),
    .dOff       (dOff),
    .cSel       (cSel),
    .cOff       (cOff),
    .directOff  (directOff)
  );

  // both register locations read the same stored bank
  assign bankRdData = cfg.bankSel;
  assign ctrlRdData = {cfg.unifiedMode, cfg.bankSel};

endmodule

// File: tb/memmap_xlat_tb_top.sv
`timescale 1ns/1ps
module memmap_xlat_tb_top;

  localparam logic [4:0] FL = 5'b00001, SR = 5'b00010, RA = 5'b00100,
                         SF = 5'b01000, NO = 5'b10000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] dAddr = '0, cAddr = '0;
  logic [7:0]  directAddr = '0;
  logic        bankWrEn = 1'b0, ctrlWrEn = 1'b0;
  logic [1:0]  bankWrData = '0;
  logic [2:0]  ctrlWrData = '0;
  logic [4:0]  dSel, cSel, sdSel, scSel;
  logic [16:0] dOff, cOff, sdOff, scOff;
  logic [12:0] directOff, sDirectOff;
  logic [1:0]  bankRdData, sBankRd;
  logic [2:0]  ctrlRdData, sCtrlRd;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  memmap_xlat dut_i (
    .clk(clk), .rstN(rstN), .dAddr(dAddr), .dSel(dSel), .dOff(dOff),
    .cAddr(cAddr), .cSel(cSel), .cOff(cOff), .directAddr(directAddr),
    .directOff(directOff), .bankWrEn(bankWrEn), .bankWrData(bankWrData),
    .bankRdData(bankRdData), .ctrlWrEn(ctrlWrEn), .ctrlWrData(ctrlWrData),
    .ctrlRdData(ctrlRdData));

  memmap_xlat #(.FLASH_BANKS(1)) small_i (
    .clk(clk), .rstN(rstN), .dAddr(dAddr), .dSel(sdSel), .dOff(sdOff),
    .cAddr(cAddr), .cSel(scSel), .cOff(scOff), .directAddr(directAddr),
    .directOff(sDirectOff), .bankWrEn(bankWrEn), .bankWrData(bankWrData),
    .bankRdData(sBankRd), .ctrlWrEn(ctrlWrEn), .ctrlWrData(ctrlWrData),
    .ctrlRdData(sCtrlRd));

  // {unified, bank, isCode, addr, expSel, expOff}
  localparam int NV = 17;
  localparam logic [41:0] VEC [NV] = '{
    {1'b0, 2'd0, 1'b0, 16'h0000, FL, 17'h00000},   // R2
    {1'b0, 2'd0, 1'b0, 16'hDEFF, FL, 17'h0DEFF},   // R2
    {1'b0, 2'd0, 1'b0, 16'hDF00, RA, 17'h00000},   // R2
    {1'b0, 2'd0, 1'b0, 16'hDF7F, RA, 17'h0007F},   // R2
    {1'b0, 2'd0, 1'b0, 16'hDF80, SF, 17'h00000},   // R2
    {1'b0, 2'd0, 1'b0, 16'hE000, SR, 17'h00000},   // R2
    {1'b0, 2'd0, 1'b0, 16'hFFFF, SR, 17'h01FFF},   // R2
    {1'b0, 2'd2, 1'b1, 16'h8000, FL, 17'h10000},   // R3
    {1'b0, 2'd3, 1'b1, 16'hFFFF, FL, 17'h1FFFF},   // R3
    {1'b0, 2'd3, 1'b1, 16'h7FFF, FL, 17'h07FFF},   // R3
    {1'b0, 2'd1, 1'b1, 16'hE000, FL, 17'h0E000},   // R3
    {1'b1, 2'd2, 1'b1, 16'hDEFF, FL, 17'h15EFF},   // R4
    {1'b1, 2'd2, 1'b1, 16'hDF10, RA, 17'h00010},   // R4
    {1'b1, 2'd1, 1'b1, 16'hF123, SR, 17'h01123},   // R4
    {1'b1, 2'd3, 1'b1, 16'h1234, FL, 17'h01234},   // R4
    {1'b1, 2'd0, 1'b1, 16'hDFC0, SF, 17'h00040},   // R4
    {1'b0, 2'd3, 1'b0, 16'h9000, FL, 17'h09000}    // R2
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic setCfg(input logic unif, input logic [1:0] bank);
    @(negedge clk);
    ctrlWrEn = 1'b1;
    ctrlWrData = {unif, bank};
    @(negedge clk);
    ctrlWrEn = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    cAddr = 16'hF000;
    #1;
    chk("R1 bank read", 32'(bankRdData), 32'h0);
    chk("R1 ctrl read", 32'(ctrlRdData), 32'h0);
    chk("R1 code F000 off", 32'(cOff), 32'h07000);
    chk("R1 code F000 sel", 32'(cSel), 32'(FL));

    for (int i = 0; i < NV; i++) begin
      logic [41:0] v;
      v = VEC[i];
      setCfg(v[41], v[40:39]);
      if (v[38]) cAddr = v[37:22]; else dAddr = v[37:22];
      #1;
      if (v[38]) begin
        chk($sformatf("R2/R3/R4 vec%0d sel", i), 32'(cSel), 32'(v[21:17]));
        chk($sformatf("R2/R3/R4 vec%0d off", i), 32'(cOff), 32'(v[16:0]));
        chk($sformatf("R10 vec%0d onehot", i), 32'($countones(cSel)), 32'd1);
      end else begin
        chk($sformatf("R2 vec%0d sel", i), 32'(dSel), 32'(v[21:17]));
        chk($sformatf("R2 vec%0d off", i), 32'(dOff), 32'(v[16:0]));
        chk($sformatf("R10 vec%0d onehot", i), 32'($countones(dSel)), 32'd1);
      end
    end

    // R4 unified code above DEFF equals data decode
    setCfg(1'b1, 2'd3);
    cAddr = 16'hDF90; dAddr = 16'hDF90;
    #1;
    chk("R4 code==data sel", 32'(cSel), 32'(dSel));
    chk("R4 code==data off", 32'(cOff), 32'(dOff));
    chk("R5 mode read", 32'(ctrlRdData[2]), 32'd1);

    // R6 mirror both directions
    setCfg(1'b0, 2'd0);
    chk("R5 mode cleared", 32'(ctrlRdData[2]), 32'd0);
    @(negedge clk); bankWrEn = 1'b1; bankWrData = 2'd2;
    @(negedge clk); bankWrEn = 1'b0;
    chk("R6 primary->ctrl", 32'(ctrlRdData[1:0]), 32'd2);
    setCfg(1'b0, 2'd1);
    chk("R6 ctrl->primary", 32'(bankRdData), 32'd1);

    // R7 collision
    @(negedge clk);
    bankWrEn = 1'b1; bankWrData = 2'd3;
    ctrlWrEn = 1'b1; ctrlWrData = 3'b101;
    @(negedge clk);
    bankWrEn = 1'b0; ctrlWrEn = 1'b0;
    chk("R7 bank primary wins", 32'(bankRdData), 32'd3);
    chk("R7 ctrl read", 32'(ctrlRdData), 32'b111);

    // R9 write timing
    setCfg(1'b0, 2'd0);
    @(negedge clk);
    cAddr = 16'h8000; bankWrEn = 1'b1; bankWrData = 2'd2;
    #1;
    chk("R9 old bank in write cycle", 32'(cOff), 32'h00000);
    @(posedge clk); #1;
    chk("R9 new bank after edge", 32'(cOff), 32'h10000);
    @(negedge clk); bankWrEn = 1'b0;

    // R8 direct data
    directAddr = 8'h00; #1;
    chk("R8 direct 00", 32'(directOff), 32'h1F00);
    directAddr = 8'hFF; dAddr = 16'hFFFF; #1;
    chk("R8 direct FF", 32'(directOff), 32'h1FFF);
    chk("R8 alias data", 32'(dOff[12:0]), 32'(directOff));

    // R11 single-bank flash
    setCfg(1'b0, 2'd2);
    dAddr = 16'h7FFF; cAddr = 16'h8000; #1;
    chk("R11 data 7FFF sel", 32'(sdSel), 32'(FL));
    chk("R11 data 7FFF off", 32'(sdOff), 32'h07FFF);
    chk("R11 code 8000 sel", 32'(scSel), 32'(NO));
    chk("R11 code 8000 off", 32'(scOff), 32'h0);
    dAddr = 16'h8000; #1;
    chk("R11 data 8000 sel", 32'(sdSel), 32'(NO));
    setCfg(1'b1, 2'd2);
    cAddr = 16'h9000; #1;
    chk("R11 unified 9000 sel", 32'(scSel), 32'(NO));
    cAddr = 16'hE000; #1;
    chk("R11 unified E000 sel", 32'(scSel), 32'(SR));
    chk("R11 unified E000 off", 32'(scOff), 32'h0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule